// File: doc/BRIEF.md
# Register-Mapped Command Mailbox Responder

This block is the device end of a two-register command mailbox reached over a plain 32-bit memory-mapped bus. Host software places a payload in a 64-bit data register, then writes a command word to an interface register with the run flag (bit 31) set. The block latches the command and holds the flag high while it works. The flag drops when the command is finished. The host polls that flag before it issues a command and again to learn that the command has completed. It then reads any result from the data register.

Commands act on a small internal store. The store holds a 32-bit interrupt-setup word and a 64-bit hint word. The setup word has a 7-bit notification time window in bits 30:24 and a row of enable flags in its lowest bits. Every bit outside those fields is kept at zero. A parameter sets how many cycles each command takes, with a minimum of one, so the host always sees the flag set at least once.

Top module: `cmd_mbox_responder`

## Requirements
- R1: After reset, the data register (both halves) reads 0, the interface register reads 0 (not busy, identifier 0), and the setup word is 0.
- R2: The address map is as follows. The data low word is at BASE_ADDR (default 0x5810), the data high word is at BASE_ADDR+4, and the interface register is at BASE_ADDR+8. Reads of the interface register return {busy, 15'b0, command identifier[15:0]}. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: A write to the interface register while idle, with bit 31 set, starts a command whose identifier is wdata[15:0]. A write with bit 31 clear is ignored.
- R4: The busy flag stays set for exactly DONE_LAT cycles after the accepting edge, so DONE_LAT back-to-back polls return busy before the first poll that returns idle.
- R5: A write to the interface register while busy is ignored. The identifier shown stays the same, and the command in flight completes as originally issued.
- R6: Writes to either half of the data register are ignored while busy.
- R7: Command 0x1E loads the setup word into the data low word and leaves the high word unchanged (32-bit response).
- R8: Command 0x1F copies the data low word into the setup word. Only bits 30:24 (time window) and bits EN_BITS-1:0 (enables, default 8) are kept, and all other bits are stored as 0. The data register is unchanged.
- R9: Command 0x11 stores all 64 data bits as the hint word. Command 0x12 returns the hint word in all 64 data bits.
- R10: Any other identifier completes in the normal way, clears all 64 data bits to zero, and leaves the setup and hint words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |

## Verification
The assertions assume that bus_wr and bus_rd are never both high in the same cycle, and that each strobe is a single-cycle pulse that carries an aligned word address. The bench always drives accesses through one write task and one read task, each of which occupies exactly one cycle, so the bus keeps to these limits. The random phase selects identifiers from the four known commands and from a block of identifiers that is known to be unused. During some busy windows it also injects a competing command and new data words, so the ignore rules are exercised while a command is in flight.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int DATA_W = 64;
   localparam int BUS_W  = 32;
   localparam int CMD_W  = 16;
   localparam int CFG_W  = 32;
   localparam int WIN_LO = 24;
   localparam int WIN_HI = 30;

   localparam logic [CMD_W-1:0] CMD_CFG_RD  = 16'h001E;
   localparam logic [CMD_W-1:0] CMD_CFG_WR  = 16'h001F;
   localparam logic [CMD_W-1:0] CMD_HINT_WR = 16'h0011;
   localparam logic [CMD_W-1:0] CMD_HINT_RD = 16'h0012;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_LO   = 2'd1,
      SEL_HI   = 2'd2,
      SEL_IF   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/mbox_regdec.sv
module mbox_regdec
   import mbox_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h5810
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] OFF_LO = BASE_ADDR;
   localparam logic [ADDR_W-1:0] OFF_HI = BASE_ADDR + ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFF_IF = BASE_ADDR + ADDR_W'(8);

   generate
      if (ADDR_W < 4) begin : g_bad_w
         $error("mbox_regdec: ADDR_W too small");
      end
      if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
         $error("mbox_regdec: BASE_ADDR must be word aligned");
      end
   endgenerate

   always_comb begin
      if (addr == OFF_LO)      sel = SEL_LO;
      else if (addr == OFF_HI) sel = SEL_HI;
      else if (addr == OFF_IF) sel = SEL_IF;
      else                     sel = SEL_NONE;
   end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
   import mbox_pkg::*;
#(
   parameter int DONE_LAT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CMD_W-1:0] cmd_in,
   output logic             busy,
   output logic             done,
   output logic [CMD_W-1:0] cmd_q
);
   generate
      if (DONE_LAT < 1) begin : g_bad_lat
         $error("mbox_seq: DONE_LAT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cmd_q <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         cmd_q <= cmd_in;
      end else if (done) begin
         busy  <= 1'b0;
      end
   end

   generate
      if (DONE_LAT == 1) begin : g_single
         assign done = busy;
      end else begin : g_count
         localparam int CNT_W = $clog2(DONE_LAT);
         localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DONE_LAT - 1);
         logic [CNT_W-1:0] remain;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               remain <= '0;
            end else if (start && !busy) begin
               remain <= CNT_LOAD;
            end else if (busy && (remain != '0)) begin
               remain <= remain - 1'b1;
            end
         end

         assign done = busy && (remain == '0);
      end
   endgenerate
endmodule

// File: rtl/mbox_store.sv
module mbox_store
   import mbox_pkg::*;
#(
   parameter int EN_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              done,
   input  logic [CMD_W-1:0]  cmd,
   output logic [DATA_W-1:0] data_q,
   output logic [CFG_W-1:0]  cfg_q
);
   logic [CFG_W-1:0]  cfg_mask;
   logic [DATA_W-1:0] hint_q;

   generate
      if (EN_BITS < 1 || EN_BITS > WIN_LO) begin : g_bad_en
         $error("mbox_store: EN_BITS must lie in 1..24");
      end
      for (genvar b = 0; b < CFG_W; b++) begin : g_mask
         if ((b >= WIN_LO && b <= WIN_HI) || b < EN_BITS) begin : g_keep
            assign cfg_mask[b] = 1'b1;
         end else begin : g_drop
            assign cfg_mask[b] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cfg_q  <= '0;
         hint_q <= '0;
      end else begin
         if (wr_lo) data_q[BUS_W-1:0]      <= wdata;
         if (wr_hi) data_q[DATA_W-1:BUS_W] <= wdata;
         if (done) begin
            unique case (cmd)
               CMD_CFG_RD:  data_q[BUS_W-1:0] <= cfg_q;
               CMD_CFG_WR:  cfg_q  <= data_q[CFG_W-1:0] & cfg_mask;
               CMD_HINT_WR: hint_q <= data_q;
               CMD_HINT_RD: data_q <= hint_q;
               default:     data_q <= '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/cmd_mbox_responder.sv
module cmd_mbox_responder
   import mbox_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h5810,
   parameter int                DONE_LAT  = 6,
   parameter int                EN_BITS   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata
);
   localparam int PAD_W = BUS_W - 1 - CMD_W;

   reg_sel_e          sel;
   logic              busy;
   logic              done;
   logic              cmd_start;
   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] data_q;
   logic [CFG_W-1:0]  cfg_q;
   logic              wr_lo;
   logic              wr_hi;

   mbox_regdec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign cmd_start = bus_wr && (sel == SEL_IF) && bus_wdata[BUS_W-1] && !busy;
   assign wr_lo     = bus_wr && (sel == SEL_LO) && !busy;
   assign wr_hi     = bus_wr && (sel == SEL_HI) && !busy;

   mbox_seq #(.DONE_LAT(DONE_LAT)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (cmd_start),
      .cmd_in (bus_wdata[CMD_W-1:0]),
      .busy   (busy),
      .done   (done),
      .cmd_q  (cmd_q)
   );

   mbox_store #(.EN_BITS(EN_BITS)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wdata  (bus_wdata),
      .done   (done),
      .cmd    (cmd_q),
      .data_q (data_q),
      .cfg_q  (cfg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         unique case (sel)
            SEL_LO:  bus_rdata <= data_q[BUS_W-1:0];
            SEL_HI:  bus_rdata <= data_q[DATA_W-1:BUS_W];
            SEL_IF:  bus_rdata <= {busy, {PAD_W{1'b0}}, cmd_q};
            default: bus_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
   import mbox_pkg::*;
#(
   parameter int DONE_LAT = 6,
   parameter int EN_BITS  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [CMD_W-1:0]  cmd_q,
   input logic [DATA_W-1:0] data_q,
   input logic [CFG_W-1:0]  cfg_q
);
   function automatic logic [CFG_W-1:0] legal_bits();
      logic [CFG_W-1:0] m;
      for (int i = 0; i < CFG_W; i++) m[i] = (i >= WIN_LO && i <= WIN_HI) || (i < EN_BITS);
      return m;
   endfunction

   localparam logic [CFG_W-1:0] LEGAL = legal_bits();

   logic [31:0] busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 1'b1;
      else           busy_len <= '0;
   end

   // R3
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R4
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == 32'(DONE_LAT)));

   // R4
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R5
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cmd_q));

   // R6
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !$past(done)) |-> $stable(data_q));

   // R8
   cfg_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q & ~LEGAL) == '0);

   // R10
   cfg_only_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_q) |-> $past(done && (cmd_q == CMD_CFG_WR)));
endmodule

bind cmd_mbox_responder mbox_chk #(.DONE_LAT(DONE_LAT), .EN_BITS(EN_BITS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (cmd_start),
   .busy   (busy),
   .done   (done),
   .cmd_q  (cmd_q),
   .data_q (data_q),
   .cfg_q  (cfg_q)
);

// File: tb/sim_cmd_mbox_responder.sv
`timescale 1ns/100ps
module sim_cmd_mbox_responder;
   import mbox_pkg::*;

   localparam int          LAT     = 6;
   localparam int          ENB     = 8;
   localparam logic [15:0] A_LO    = 16'h5810;
   localparam logic [15:0] A_HI    = 16'h5814;
   localparam logic [15:0] A_IF    = 16'h5818;
   localparam logic [31:0] KEEP    = 32'h7F00_00FF;
   localparam int          MAX_CYC = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   logic [63:0] m_data;
   logic [31:0] m_cfg;
   logic [63:0] m_hint;
   logic [15:0] m_id;

   always #2.5 clk = ~clk;

   cmd_mbox_responder #(.DONE_LAT(LAT), .EN_BITS(ENB)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > MAX_CYC) begin
         fails = fails + 1;
         $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, MAX_CYC);
         summary();
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [63:0] result_data(input logic [15:0] id, input logic [63:0] d,
                                               input logic [31:0] c, input logic [63:0] h);
      case (id)
         CMD_CFG_RD:  return {d[63:32], c};
         CMD_CFG_WR:  return d;
         CMD_HINT_WR: return d;
         CMD_HINT_RD: return h;
         default:     return 64'h0;
      endcase
   endfunction

   task automatic model_cmd(input logic [15:0] id);
      logic [63:0] nd;
      nd = result_data(id, m_data, m_cfg, m_hint);
      if (id == CMD_CFG_WR)  m_cfg  = m_data[31:0] & KEEP;
      if (id == CMD_HINT_WR) m_hint = m_data;
      m_data = nd;
   endtask

   task automatic check_data(input string tag);
      logic [31:0] lo, hi;
      rd(A_LO, lo);
      rd(A_HI, hi);
      chk(tag, {hi, lo}, m_data);
   endtask

   // issue a command, optionally disturb the mailbox while busy, poll, check
   task automatic run_cmd(input logic [15:0] id, input bit disturb, input string tag);
      logic [31:0] v;
      int n;
      wr(A_IF, 32'h8000_0000 | 32'(id));
      m_id = id;
      if (disturb) begin
         wr(A_IF, 32'h8000_0000 | 32'(CMD_HINT_RD ^ id));  // R5 ignored
         wr(A_LO, $urandom);                               // R6 ignored
         wr(A_HI, $urandom);                               // R6 ignored
      end
      n = 0;
      do begin
         rd(A_IF, v);
         if (v[31]) n++;
      end while (v[31] && n < 1000);
      chk({tag, " R5 id"}, 64'(v[15:0]), 64'(m_id));
      chk({tag, " R4 polls"}, 64'(n), disturb ? 64'(LAT - 3) : 64'(LAT));
      model_cmd(id);
      check_data({tag, " result"});
   endtask

   task automatic load_data(input logic [63:0] d);
      wr(A_LO, d[31:0]);
      wr(A_HI, d[63:32]);
      m_data = d;
   endtask

   initial begin
      logic [31:0] v;
      logic [15:0] id;
      void'($urandom(32'd7351));
      m_data = '0; m_cfg = '0; m_hint = '0; m_id = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_IF, v);  chk("R1 iface", 64'(v), 64'h0);
      check_data("R1 data");
      run_cmd(CMD_CFG_RD, 1'b0, "R1 cfg zero");

      // R2 unmapped address: read 0, write no effect
      load_data(64'h1122_3344_5566_7788);
      wr(16'h5820, 32'hFFFF_FFFF);
      wr(16'h580C, 32'hFFFF_FFFF);
      rd(16'h5820, v); chk("R2 unmapped read", 64'(v), 64'h0);
      check_data("R2 unmapped write");

      // R8 setup write masks reserved bits
      load_data(64'hDEAD_BEEF_FFFF_FFFF);
      run_cmd(CMD_CFG_WR, 1'b0, "R8 cfg wr");
      load_data(64'hAAAA_5555_0000_0000);
      run_cmd(CMD_CFG_RD, 1'b0, "R7 cfg rd keeps high");
      chk("R8 cfg value", 64'(m_data[31:0]), 64'h7F00_00FF);

      // R3 run flag clear: ignored
      wr(A_IF, 32'h0000_00AB);
      rd(A_IF, v); chk("R3 no start", 64'(v), 64'(m_id));
      check_data("R3 data untouched");

      // R9 64-bit hint round trip
      load_data(64'h0123_4567_89AB_CDEF);
      run_cmd(CMD_HINT_WR, 1'b0, "R9 hint wr");
      load_data(64'h0);
      run_cmd(CMD_HINT_RD, 1'b0, "R9 hint rd");

      // R10 unknown identifier: zero data, stores kept
      load_data(64'hFFFF_FFFF_FFFF_FFFF);
      run_cmd(16'hFFFF, 1'b0, "R10 unknown");
      run_cmd(CMD_CFG_RD, 1'b0, "R10 cfg kept");
      run_cmd(CMD_HINT_RD, 1'b0, "R10 hint kept");

      // R5 R6 disturbed busy window
      load_data(64'h0000_0000_2A00_0013);
      run_cmd(CMD_CFG_WR, 1'b1, "R6 disturbed cfg wr");
      run_cmd(CMD_CFG_RD, 1'b1, "R5 disturbed cfg rd");

      // random mix
      for (int i = 0; i < 80; i++) begin
         case ($urandom % 5)
            0: id = CMD_CFG_RD;
            1: id = CMD_CFG_WR;
            2: id = CMD_HINT_WR;
            3: id = CMD_HINT_RD;
            default: id = 16'h0100 | 16'($urandom % 256);
         endcase
         if ($urandom % 2 == 1) load_data({$urandom, $urandom});
         run_cmd(id, ($urandom % 3) == 0, "R7 R8 R9 R10 random");
      end

      summary();
   end
endmodule